// File: doc/BRIEF.md
# Low-Power Mode Controller with Wake Qualification

This block sits beside a small processor core and controls three clock enables: one for the oscillator, one for the core's input clock and one for the system clock output. When the core executes its idle instruction it sends a one-cycle request strobe. The controller then enters one of three sleep depths, chosen by a 2-bit field in its control register. Each depth gates a different set of clocks and accepts a different set of wake events.

The lightest depth keeps every clock running and wakes on the first interrupt. The middle depth stops the core clocks but keeps the oscillator running. It wakes only on sources enabled in a per-source mask, and only after such a source has stayed low for a programmed number of oscillator cycles. Glitches shorter than that are filtered out. The deepest depth stops everything and wakes only on reset or on an enabled non-maskable interrupt. On that exit the oscillator is brought back first, and the core clocks follow after a fixed settle interval.

Software programs the depth, the non-maskable-interrupt enable, the qualification count and the wake mask through a small write port. Wake bit 0 carries the watchdog interrupt. The remaining wake bits carry the external-interrupt, timer/compare trip, serial receive and CAN receive lines, in whatever order the integration chooses.

Top module: `lpm_ctrl`

## Requirements
- R1: A synchronous reset (rst high at an edge) puts the block in the run state with osc_en, cpuclk_en and sysclk_en at 1 and wake_pulse at 0. It also clears the control and mask registers to zero, from any state.
- R2: A one-cycle idle_req in the run state enters a sleep depth from the control field bits[1:0]; the enables change at that same clock edge.
  - 00 gives the light depth, with all three enables still 1.
  - 01 gives the middle depth, with osc_en 1 and cpuclk_en and sysclk_en 0.
  - 10 and 11 both give the deep depth, with all three enables 0.
- R3: idle_req has no effect while the block is in any sleep depth or in the settle phase.
- R4: In the light depth, any one of the following returns the block to the run state at the next edge with a wake pulse: irq_n low, wake_n[0] (watchdog) low, or nmi_n low while the NMI enable bit is 1. nmi_n has no effect while that bit is 0.
- R5: In the middle depth, only the wake_n bits whose mask bit is 1 can wake the block. irq_n, nmi_n and unmasked wake bits have no effect.
- R6: In the middle depth, a selected wake input that is sampled low at qual+1 consecutive edges wakes the block at the last of those edges. A low run of fewer edges does not wake it. The count restarts whenever all selected inputs are sampled high.
- R7: In the deep depth, only nmi_n low while the NMI enable bit is 1 starts an exit. irq_n, all wake_n bits and nmi_n with the enable bit at 0 leave every enable at 0.
- R8: A deep-depth exit sets osc_en to 1 at the edge that samples the NMI. cpuclk_en and sysclk_en stay 0 for 16 clock cycles and return to 1 at the 16th edge after that one.
- R9: wake_pulse is 1 for exactly one cycle. It rises at the edge where the core clocks are restored.
- R10: Writes use cfg_we with cfg_sel selecting the register.
  - cfg_sel=0 writes the control register: bits[1:0] are the depth, bit[2] is the NMI enable and bits[10:3] are the qualification count.
  - cfg_sel=1 writes the mask register from bits[7:0]; mask bit n enables wake_n[n].
- R11: sysclk_en always equals cpuclk_en, and cpuclk_en is never 1 while osc_en is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | Register select: 0 = control, 1 = wake mask |
| cfg_wdata | input | 16 | Register write data |
| idle_req | input | 1 | One-cycle sleep request from the core |
| irq_n | input | 1 | Active-low enabled-interrupt line (light depth wake) |
| nmi_n | input | 1 | Active-low non-maskable interrupt |
| wake_n | input | 8 | Active-low wake sources; bit 0 is the watchdog interrupt |
| osc_en | output | 1 | Oscillator enable |
| cpuclk_en | output | 1 | Core input clock enable |
| sysclk_en | output | 1 | System clock output enable |
| wake_pulse | output | 1 | One-cycle wake indication to the core |

## Verification
The clock enables are registered from the next state, so they change at the same edge that samples idle_req or a wake event. The exceptions are the middle depth, which changes them at the (qual+1)-th edge of a qualified low run, and the settle phase, which restores the core clocks at the 16th edge. The bench drives inputs just after a falling edge and samples on the following falling edge, so every check sees the result of exactly the rising edges it has counted. Filter and ignore cases are checked one edge short of the due time and again after extra idle cycles. This shows that nothing changed at the ports.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_LIGHT,
    ST_MID,
    ST_DEEP,
    ST_SETTLE
  } lpm_state_e;

  typedef enum logic [1:0] {
    DEPTH_LIGHT,
    DEPTH_MID,
    DEPTH_DEEP
  } depth_e;

  function automatic depth_e depth_of(input logic [1:0] field);
    if (field[1])      return DEPTH_DEEP;
    else if (field[0]) return DEPTH_MID;
    else               return DEPTH_LIGHT;
  endfunction

endpackage

// File: rtl/lpm_regs.sv
module lpm_regs #(
  parameter int DW   = 16,
  parameter int NSRC = 8,
  parameter int QW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [1:0]      depth_f,
  output logic            nmi_en,
  output logic [QW-1:0]   qual,
  output logic [NSRC-1:0] mask
);
  localparam int NMI_BIT = 2;
  localparam int Q_LSB   = 3;
  localparam int Q_MSB   = Q_LSB + QW - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_f <= '0;
      nmi_en  <= 1'b0;
      qual    <= '0;
      mask    <= '0;
    end else if (cfg_we) begin
      if (!cfg_sel) begin
        depth_f <= cfg_wdata[1:0];
        nmi_en  <= cfg_wdata[NMI_BIT];
        qual    <= cfg_wdata[Q_MSB:Q_LSB];
      end else begin
        mask    <= cfg_wdata[NSRC-1:0];
      end
    end
  end
endmodule

// File: rtl/lpm_qual.sv
module lpm_qual #(
  parameter int NSRC = 8,
  parameter int QW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic [NSRC-1:0] wake_n,
  input  logic [NSRC-1:0] mask,
  input  logic [QW-1:0]   qual,
  output logic            hit
);
  logic [QW-1:0] cnt;
  logic          any_low;

  assign any_low = |(~wake_n & mask);
  assign hit     = active && any_low && (cnt == qual);

  always_ff @(posedge clk) begin
    if (rst || !active || !any_low) cnt <= '0;
    else if (!hit)                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idle_req,
  input  logic [1:0] depth_f,
  input  logic       nmi_en,
  input  logic       nmi_n,
  input  logic       irq_n,
  input  logic       wd_n,
  input  logic       qual_hit,
  output logic       mid_active,
  output logic       osc_en,
  output logic       cpuclk_en,
  output logic       sysclk_en,
  output logic       wake_pulse
);
  localparam int SW = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SW-1:0] S_LAST = SW'(SETTLE_CYC - 1);

  lpm_state_e    st, nxt;
  logic          wake_nx;
  logic [SW-1:0] scnt;
  logic          nmi_hit;

  assign nmi_hit    = nmi_en && !nmi_n;
  assign mid_active = (st == ST_MID);

  always_comb begin
    nxt     = st;
    wake_nx = 1'b0;
    unique case (st)
      ST_RUN: if (idle_req) begin
        unique case (depth_of(depth_f))
          DEPTH_LIGHT: nxt = ST_LIGHT;
          DEPTH_MID:   nxt = ST_MID;
          default:     nxt = ST_DEEP;
        endcase
      end
      ST_LIGHT: if (!irq_n || !wd_n || nmi_hit) begin
        nxt = ST_RUN; wake_nx = 1'b1;
      end
      ST_MID: if (qual_hit) begin
        nxt = ST_RUN; wake_nx = 1'b1;
      end
      ST_DEEP: if (nmi_hit) nxt = ST_SETTLE;
      ST_SETTLE: if (scnt == S_LAST) begin
        nxt = ST_RUN; wake_nx = 1'b1;
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_RUN;
      osc_en     <= 1'b1;
      cpuclk_en  <= 1'b1;
      sysclk_en  <= 1'b1;
      wake_pulse <= 1'b0;
      scnt       <= '0;
    end else begin
      st         <= nxt;
      osc_en     <= (nxt != ST_DEEP);
      cpuclk_en  <= (nxt == ST_RUN) || (nxt == ST_LIGHT);
      sysclk_en  <= (nxt == ST_RUN) || (nxt == ST_LIGHT);
      wake_pulse <= wake_nx;
      scnt       <= (st == ST_SETTLE) ? scnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int DW         = 16,
  parameter int NSRC       = 8,
  parameter int QW         = 8,
  parameter int SETTLE_CYC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            idle_req,
  input  logic            irq_n,
  input  logic            nmi_n,
  input  logic [NSRC-1:0] wake_n,
  output logic            osc_en,
  output logic            cpuclk_en,
  output logic            sysclk_en,
  output logic            wake_pulse
);
  logic [1:0]      depth_f;
  logic            nmi_en;
  logic [QW-1:0]   qual;
  logic [NSRC-1:0] mask;
  logic            mid_active;
  logic            qual_hit;

  lpm_regs #(.DW(DW), .NSRC(NSRC), .QW(QW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .depth_f(depth_f), .nmi_en(nmi_en),
    .qual(qual), .mask(mask)
  );

  lpm_qual #(.NSRC(NSRC), .QW(QW)) u_qual (
    .clk(clk), .rst(rst), .active(mid_active), .wake_n(wake_n),
    .mask(mask), .qual(qual), .hit(qual_hit)
  );

  lpm_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst(rst), .idle_req(idle_req), .depth_f(depth_f),
    .nmi_en(nmi_en), .nmi_n(nmi_n), .irq_n(irq_n), .wd_n(wake_n[0]),
    .qual_hit(qual_hit), .mid_active(mid_active), .osc_en(osc_en),
    .cpuclk_en(cpuclk_en), .sysclk_en(sysclk_en), .wake_pulse(wake_pulse)
  );
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic idle_req,
  input logic osc_en,
  input logic cpuclk_en,
  input logic sysclk_en,
  input logic wake_pulse
);
  AST_RESET_CLOCKS_ON: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (osc_en && cpuclk_en && sysclk_en && !wake_pulse)); // R1
  AST_CLK_OFF_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(cpuclk_en) |-> $past(idle_req)); // R2
  AST_OSC_OFF_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(osc_en) |-> $past(idle_req)); // R7
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse); // R9
  AST_WAKE_CLOCKS_ON: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (cpuclk_en && osc_en)); // R9
  AST_SYS_TRACKS_CPU: assert property (@(posedge clk) disable iff (rst)
    sysclk_en == cpuclk_en); // R11
  AST_CPU_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
    cpuclk_en |-> osc_en); // R11
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .idle_req(idle_req), .osc_en(osc_en),
  .cpuclk_en(cpuclk_en), .sysclk_en(sysclk_en), .wake_pulse(wake_pulse)
);

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        idle_req = 1'b0;
  logic        irq_n = 1'b1;
  logic        nmi_n = 1'b1;
  logic [7:0]  wake_n = 8'hFF;
  logic        osc_en, cpuclk_en, sysclk_en, wake_pulse;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lpm_ctrl dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .idle_req(idle_req), .irq_n(irq_n),
    .nmi_n(nmi_n), .wake_n(wake_n), .osc_en(osc_en),
    .cpuclk_en(cpuclk_en), .sysclk_en(sysclk_en), .wake_pulse(wake_pulse)
  );

  // {control word, osc, cpu, sys} after the entry strobe
  localparam logic [18:0] VEC [4] = '{
    {16'h0000, 3'b111},   // light depth
    {16'h0001, 3'b100},   // middle depth
    {16'h0002, 3'b000},   // deep depth
    {16'h0003, 3'b000}    // deep depth, low bit set
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic strobe();
    idle_req = 1'b1;
    step();
    idle_req = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  function automatic logic [2:0] ens();
    return {osc_en, cpuclk_en, sysclk_en};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    chk("R1 enables after reset", ens(), 3'b111);
    chk("R1 wake_pulse after reset", wake_pulse, 1'b0);

    // R2 table walk
    for (int i = 0; i < 4; i++) begin
      do_reset();
      wr(1'b0, VEC[i][18:3]);
      step();
      chk("R2 enables idle before strobe", ens(), 3'b111);
      strobe();
      chk("R2 enables after strobe", ens(), VEC[i][2:0]);
      step(3);
      chk("R2 enables held", ens(), VEC[i][2:0]);
    end

    // R1 reset from deep depth, registers cleared
    do_reset(); wr(1'b0, 16'h0002); strobe();
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 reset exits deep depth", ens(), 3'b111);
    strobe();
    chk("R1 R10 control cleared to light depth", ens(), 3'b111);
    irq_n = 1'b0; step(); irq_n = 1'b1;
    chk("R4 irq wakes light depth", wake_pulse, 1'b1);
    step();
    chk("R9 wake pulse one cycle", wake_pulse, 1'b0);

    // R4 watchdog and NMI in light depth
    strobe(); wake_n[0] = 1'b0; step(); wake_n[0] = 1'b1;
    chk("R4 watchdog wakes light depth", wake_pulse, 1'b1);
    step();
    nmi_n = 1'b0; strobe(); step(3);
    chk("R4 nmi ignored with enable 0", wake_pulse, 1'b0);
    nmi_n = 1'b1;
    wr(1'b0, 16'h0004); nmi_n = 1'b0; step(); nmi_n = 1'b1;
    chk("R4 nmi wakes with enable 1", wake_pulse, 1'b1);
    step();

    // R5/R6 middle depth qualification, qual=3 at bits[10:3], mask bit 3
    do_reset();
    wr(1'b0, 16'h0019);      // depth 01, qual 3
    wr(1'b1, 16'h0008);
    strobe();
    chk("R2 middle depth entered", ens(), 3'b100);
    wake_n[5] = 1'b0; irq_n = 1'b0; nmi_n = 1'b0; step(8);
    wake_n[5] = 1'b1; irq_n = 1'b1; nmi_n = 1'b1;
    chk("R5 unmasked sources ignored", ens(), 3'b100);
    wake_n[3] = 1'b0; step(3); wake_n[3] = 1'b1;
    chk("R6 short pulse filtered", ens(), 3'b100);
    step(2);
    chk("R6 still asleep after short pulse", ens(), 3'b100);
    wake_n[3] = 1'b0; step(3);
    chk("R6 not yet at qual edges", ens(), 3'b100);
    step();
    wake_n[3] = 1'b1;
    chk("R6 wake at qual+1 edges", ens(), 3'b111);
    chk("R9 wake pulse on middle exit", wake_pulse, 1'b1);
    step();
    chk("R9 wake pulse cleared", wake_pulse, 1'b0);

    // R3 strobe ignored while asleep
    strobe();
    wr(1'b0, 16'h0002);
    strobe();
    chk("R3 strobe ignored in middle depth", ens(), 3'b100);

    // R7/R8 deep depth
    do_reset();
    wr(1'b0, 16'h0002);
    wr(1'b1, 16'h00FF);
    strobe();
    wake_n = 8'h00; irq_n = 1'b0; nmi_n = 1'b0; step(6);
    wake_n = 8'hFF; irq_n = 1'b1; nmi_n = 1'b1;
    chk("R7 deep ignores all but enabled nmi", ens(), 3'b000);
    wr(1'b0, 16'h0006);
    chk("R7 still deep after register write", ens(), 3'b000);
    nmi_n = 1'b0; step(); nmi_n = 1'b1;
    chk("R8 oscillator first", ens(), 3'b100);
    strobe();
    step(14);
    chk("R8 core clocks held through settle", ens(), 3'b100);
    chk("R8 no wake during settle", wake_pulse, 1'b0);
    step();
    chk("R8 core clocks restored at 16th edge", ens(), 3'b111);
    chk("R9 wake pulse on deep exit", wake_pulse, 1'b1);
    step();
    chk("R9 wake pulse one cycle after deep", wake_pulse, 1'b0);
    chk("R11 sysclk follows cpuclk", sysclk_en, cpuclk_en);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule